// File: doc/BRIEF.md
# Trap Instruction Transformation Unit

When a synchronous memory trap is taken on a hypervisor-capable RISC-V core, the trap handler needs a compact description of the instruction that faulted. It should not have to fetch and decode guest memory to get it. This block builds that description. Each trap commit gives it the raw trapping instruction, the exception cause, two translation flags, the faulting and original addresses, and the current XLEN. It returns the value for the trap-instruction CSR, and that value is held until the next commit.

Ordinary loads and stores come out in a rewritten form. The immediate is cleared to zero. A compressed encoding is widened to its 32-bit form, with bit 1 cleared to show that the original was 2 bytes long. The rs1 field carries the byte distance from the original virtual address to the address that actually faulted. Atomics and hypervisor loads and stores are copied unchanged. A fault taken by the implicit access of a guest page-table walk gives a fixed pseudoinstruction. Anything the block does not recognise gives zero.

Top module: `trap_tinst_xform`

## Requirements
- R1: For a 32-bit LOAD (opcode 0000011), STORE (0100011), or scalar FP load/store (opcodes 0000111/0100111 with funct3 001..100) under a load/store cause, bits 31:20 (loads), or bits 31:25 and 11:7 (stores), of the result are zero. All other fields are copied.
- R2: In every rewritten load/store, bits 19:15 hold (faulting address − original address) modulo 32.
- R3: Under the misaligned causes 4 and 6, the offset in bits 19:15 is forced to zero.
- R4: A compressed load/store in quadrant 00 or 10 is expanded as follows. Funct3 001/010/101/110 give FLD/LW/FSD/SW. Quadrant 00 takes the register from bits 4:2 plus 8. Quadrant 10 takes rd from bits 11:7 (loads) or rs2 from bits 6:2 (stores).
- R5: The result for a compressed source has bits 1:0 not equal to 11, because bit 1 is cleared. For a 32-bit source, bits 1:0 stay 11.
- R6: Compressed funct3 011/111 expand to LD/SD when the RV64 input is 1, and to FLW/FSW when it is 0.
- R7: Opcode 0101111 (atomics) and opcode 1110011 with funct3 100 (hypervisor load/store) pass through unchanged.
- R8: Vector forms (FP load/store opcodes with funct3 000, 101, 110 or 111), any other opcode, and any compressed word that is not a load/store give zero under a load/store cause.
- R9: Causes 21 and 23 with the walk flag set give 0x00002000 when RV64 is 0 and 0x00003000 when RV64 is 1.
- R10: Cause 20 gives the pseudoinstruction of R9 when the two-stage flag is set, and zero otherwise.
- R11: Causes 0, 1 and 12, and any cause other than 4, 5, 6, 7, 13, 15, 20, 21 and 23, give zero.
- R12: The output updates only in the cycle after a commit strobe, holds otherwise, and resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_i | input | 1 | Trap-commit strobe, captures the result |
| insn_i | input | 32 | Trapping instruction (compressed in bits 15:0) |
| cause_i | input | CAUSE_W | Exception cause code |
| two_stage_i | input | 1 | Two-stage translation was active |
| walk_i | input | 1 | Fault came from an implicit guest page-table walk access |
| fault_addr_i | input | ADDR_W | Address that faulted |
| orig_addr_i | input | ADDR_W | Original virtual address of the access |
| xlen64_i | input | 1 | 1 for RV64, 0 for RV32 |
| tinst_o | output | 32 | Registered transformed instruction |

## Verification
The hardest state to reach is a nonzero offset surviving into rs1. That needs a load/store cause that is not a misaligned one, together with a faulting address placed a few bytes past the original address, as in an access that straddles a page boundary. The stimulus table sets the two addresses directly. It puts them at 0xa00ffe and 0xa01000, and also 0x23 bytes apart to exercise truncation. The same instruction is then repeated under a misaligned cause to show that the offset is suppressed.

// File: rtl/tinst_pkg.sv
package tinst_pkg;

    localparam int unsigned TINST_W = 32;
    localparam int unsigned OFF_W   = 5;

    localparam logic [6:0] OPC_LOAD    = 7'b0000011;
    localparam logic [6:0] OPC_LOADFP  = 7'b0000111;
    localparam logic [6:0] OPC_STORE   = 7'b0100011;
    localparam logic [6:0] OPC_STOREFP = 7'b0100111;
    localparam logic [6:0] OPC_AMO     = 7'b0101111;
    localparam logic [6:0] OPC_SYSTEM  = 7'b1110011;

    localparam int CAUSE_I_MISAL  = 0;
    localparam int CAUSE_I_ACCESS = 1;
    localparam int CAUSE_L_MISAL  = 4;
    localparam int CAUSE_L_ACCESS = 5;
    localparam int CAUSE_S_MISAL  = 6;
    localparam int CAUSE_S_ACCESS = 7;
    localparam int CAUSE_I_PAGE   = 12;
    localparam int CAUSE_L_PAGE   = 13;
    localparam int CAUSE_S_PAGE   = 15;
    localparam int CAUSE_I_GUEST  = 20;
    localparam int CAUSE_L_GUEST  = 21;
    localparam int CAUSE_S_GUEST  = 23;

    localparam logic [TINST_W-1:0] PSEUDO_WALK32 = 32'h0000_2000;
    localparam logic [TINST_W-1:0] PSEUDO_WALK64 = 32'h0000_3000;

    typedef struct packed {
        logic ldst;
        logic misal;
        logic guest_ldst;
        logic fetch_guest;
    } cause_cls_t;

    typedef struct packed {
        logic [TINST_W-1:0] tinst;
    } tinst_state_t;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_LOAD,
        CK_STORE
    } ckind_e;

endpackage

// File: rtl/tinst_cause_class.sv
module tinst_cause_class
    import tinst_pkg::*;
#(
    parameter int unsigned CAUSE_W = 6
) (
    input  logic [CAUSE_W-1:0] cause_i,
    output cause_cls_t         cls_o
);

    always_comb begin
        cls_o = '0;
        case (cause_i)
            CAUSE_W'(CAUSE_L_MISAL), CAUSE_W'(CAUSE_S_MISAL): begin
                cls_o.ldst  = 1'b1;
                cls_o.misal = 1'b1;
            end
            CAUSE_W'(CAUSE_L_ACCESS), CAUSE_W'(CAUSE_S_ACCESS),
            CAUSE_W'(CAUSE_L_PAGE),   CAUSE_W'(CAUSE_S_PAGE): begin
                cls_o.ldst = 1'b1;
            end
            CAUSE_W'(CAUSE_L_GUEST), CAUSE_W'(CAUSE_S_GUEST): begin
                cls_o.ldst       = 1'b1;
                cls_o.guest_ldst = 1'b1;
            end
            CAUSE_W'(CAUSE_I_GUEST): begin
                cls_o.fetch_guest = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tinst_full_xform.sv
module tinst_full_xform
    import tinst_pkg::*;
(
    input  logic [TINST_W-1:0] insn_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [TINST_W-1:0] xf_o
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic       fp_scalar;

    always_comb begin
        opc       = insn_i[6:0];
        f3        = insn_i[14:12];
        fp_scalar = (f3 == 3'b001) || (f3 == 3'b010) || (f3 == 3'b011) || (f3 == 3'b100);
        xf_o      = '0;
        case (opc)
            OPC_LOAD: begin
                xf_o = {12'b0, off_i, insn_i[14:0]};
            end
            OPC_LOADFP: begin
                if (fp_scalar) xf_o = {12'b0, off_i, insn_i[14:0]};
            end
            OPC_STORE: begin
                xf_o = {7'b0, insn_i[24:20], off_i, f3, 5'b0, opc};
            end
            OPC_STOREFP: begin
                if (fp_scalar) xf_o = {7'b0, insn_i[24:20], off_i, f3, 5'b0, opc};
            end
            OPC_AMO: begin
                xf_o = insn_i;
            end
            OPC_SYSTEM: begin
                if (f3 == 3'b100) xf_o = insn_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tinst_rvc_expand.sv
module tinst_rvc_expand
    import tinst_pkg::*;
(
    input  logic [15:0]        c_i,
    input  logic               xlen64_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [TINST_W-1:0] xf_o
);

    ckind_e     kind;
    logic [2:0] f3;
    logic [6:0] opc;
    logic [4:0] reg_f;
    logic       unused_bit12;

    assign unused_bit12 = c_i[12];

    always_comb begin
        kind = CK_NONE;
        f3   = '0;
        opc  = '0;
        if ((c_i[1:0] == 2'b00) || (c_i[1:0] == 2'b10)) begin
            case (c_i[15:13])
                3'b001: begin kind = CK_LOAD;  f3 = 3'b011; opc = OPC_LOADFP;  end
                3'b010: begin kind = CK_LOAD;  f3 = 3'b010; opc = OPC_LOAD;    end
                3'b011: begin
                    kind = CK_LOAD;
                    f3   = xlen64_i ? 3'b011   : 3'b010;
                    opc  = xlen64_i ? OPC_LOAD : OPC_LOADFP;
                end
                3'b101: begin kind = CK_STORE; f3 = 3'b011; opc = OPC_STOREFP; end
                3'b110: begin kind = CK_STORE; f3 = 3'b010; opc = OPC_STORE;   end
                3'b111: begin
                    kind = CK_STORE;
                    f3   = xlen64_i ? 3'b011    : 3'b010;
                    opc  = xlen64_i ? OPC_STORE : OPC_STOREFP;
                end
                default: ;
            endcase
        end

        if (c_i[1:0] == 2'b00)  reg_f = {2'b01, c_i[4:2]};
        else if (kind == CK_LOAD) reg_f = c_i[11:7];
        else                      reg_f = c_i[6:2];

        case (kind)
            CK_LOAD:  xf_o = {12'b0, off_i, f3, reg_f, opc};
            CK_STORE: xf_o = {7'b0, reg_f, off_i, f3, 5'b0, opc};
            default:  xf_o = '0;
        endcase
    end

endmodule

// File: rtl/trap_tinst_xform.sv
module trap_tinst_xform
    import tinst_pkg::*;
#(
    parameter int unsigned CAUSE_W = 6,
    parameter int unsigned ADDR_W  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_i,
    input  logic [31:0]         insn_i,
    input  logic [CAUSE_W-1:0]  cause_i,
    input  logic                two_stage_i,
    input  logic                walk_i,
    input  logic [ADDR_W-1:0]   fault_addr_i,
    input  logic [ADDR_W-1:0]   orig_addr_i,
    input  logic                xlen64_i,
    output logic [31:0]         tinst_o
);

    cause_cls_t          cls;
    logic [ADDR_W-1:0]   span;
    logic [OFF_W-1:0]    raw_off;
    logic [OFF_W-1:0]    off;
    logic [TINST_W-1:0]  full_xf;
    logic [TINST_W-1:0]  rvc_xf;
    logic [TINST_W-1:0]  pseudo;
    logic [TINST_W-1:0]  next_val;
    logic                is_short;
    tinst_state_t        state_d, state_q;

    assign span = fault_addr_i - orig_addr_i;

    generate
        if (ADDR_W > OFF_W) begin : g_trunc
            logic unused_hi;
            assign raw_off   = span[OFF_W-1:0];
            assign unused_hi = ^span[ADDR_W-1:OFF_W];
        end else begin : g_pad
            assign raw_off = OFF_W'(span);
        end
    endgenerate

    tinst_cause_class #(.CAUSE_W(CAUSE_W)) u_cls (
        .cause_i (cause_i),
        .cls_o   (cls)
    );

    assign off    = cls.misal ? '0 : raw_off;
    assign pseudo = xlen64_i ? PSEUDO_WALK64 : PSEUDO_WALK32;

    tinst_full_xform u_full (
        .insn_i (insn_i),
        .off_i  (off),
        .xf_o   (full_xf)
    );

    tinst_rvc_expand u_rvc (
        .c_i      (insn_i[15:0]),
        .xlen64_i (xlen64_i),
        .off_i    (off),
        .xf_o     (rvc_xf)
    );

    always_comb begin
        is_short = (insn_i[1:0] != 2'b11);
        next_val = '0;
        if (cls.fetch_guest) begin
            next_val = two_stage_i ? pseudo : '0;
        end else if (cls.ldst) begin
            if (walk_i && cls.guest_ldst) next_val = pseudo;
            else if (is_short)            next_val = rvc_xf & ~TINST_W'(2);
            else                          next_val = full_xf;
        end
        state_d = state_q;
        if (commit_i) state_d.tinst = next_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign tinst_o = state_q.tinst;

endmodule

// File: rtl/trap_tinst_xform_chk.sv
module trap_tinst_xform_chk
    import tinst_pkg::*;
#(
    parameter int unsigned CAUSE_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               commit_i,
    input logic [31:0]        insn_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic               two_stage_i,
    input logic               walk_i,
    input logic               xlen64_i,
    input logic [31:0]        tinst_o
);

    logic ldst_c, misal_c, walk_c, fetch_c;

    assign misal_c = (cause_i == CAUSE_W'(CAUSE_L_MISAL)) || (cause_i == CAUSE_W'(CAUSE_S_MISAL));
    assign walk_c  = (cause_i == CAUSE_W'(CAUSE_L_GUEST)) || (cause_i == CAUSE_W'(CAUSE_S_GUEST));
    assign ldst_c  = misal_c || walk_c
                  || (cause_i == CAUSE_W'(CAUSE_L_ACCESS)) || (cause_i == CAUSE_W'(CAUSE_S_ACCESS))
                  || (cause_i == CAUSE_W'(CAUSE_L_PAGE))   || (cause_i == CAUSE_W'(CAUSE_S_PAGE));
    assign fetch_c = (cause_i == CAUSE_W'(CAUSE_I_MISAL)) || (cause_i == CAUSE_W'(CAUSE_I_ACCESS))
                  || (cause_i == CAUSE_W'(CAUSE_I_PAGE));

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(tinst_o)); // R12

    AST_WALK_RV32: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && walk_i && walk_c && !xlen64_i |=> tinst_o == 32'h0000_2000); // R9

    AST_WALK_RV64: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && walk_i && walk_c && xlen64_i |=> tinst_o == 32'h0000_3000); // R9

    AST_GFETCH_NO2S: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && (cause_i == CAUSE_W'(CAUSE_I_GUEST)) && !two_stage_i |=> tinst_o == '0); // R10

    AST_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && fetch_c |=> tinst_o == '0); // R11

    AST_LOAD_IMM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && ldst_c && !walk_i && insn_i[6:0] == OPC_LOAD |=> tinst_o[31:20] == '0); // R1

    AST_MISAL_NO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && misal_c && insn_i[6:0] == OPC_LOAD |=> tinst_o[19:15] == '0); // R3

    AST_SHORT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i && ldst_c && !walk_i && insn_i[1:0] != 2'b11 |=> tinst_o[1:0] != 2'b11); // R5

endmodule

bind trap_tinst_xform trap_tinst_xform_chk #(.CAUSE_W(CAUSE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_i    (commit_i),
    .insn_i      (insn_i),
    .cause_i     (cause_i),
    .two_stage_i (two_stage_i),
    .walk_i      (walk_i),
    .xlen64_i    (xlen64_i),
    .tinst_o     (tinst_o)
);

// File: tb/trap_tinst_xform_bench.sv
module trap_tinst_xform_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        commit_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [5:0]  cause_i = '0;
    logic        two_stage_i = 1'b0;
    logic        walk_i = 1'b0;
    logic [63:0] fault_addr_i = '0;
    logic [63:0] orig_addr_i = '0;
    logic        xlen64_i = 1'b0;
    logic [31:0] tinst_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trap_tinst_xform u_trap_tinst_xform (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_i     (commit_i),
        .insn_i       (insn_i),
        .cause_i      (cause_i),
        .two_stage_i  (two_stage_i),
        .walk_i       (walk_i),
        .fault_addr_i (fault_addr_i),
        .orig_addr_i  (orig_addr_i),
        .xlen64_i     (xlen64_i),
        .tinst_o      (tinst_o)
    );

    typedef struct packed {
        logic [31:0] insn;
        logic [5:0]  cause;
        logic        two;
        logic        walk;
        logic [63:0] fault;
        logic [63:0] orig;
        logic        x64;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{32'h00853283, 6'd13, 1'b0, 1'b0, 64'ha01000, 64'ha00ffe, 1'b1, 32'h00013283, 4'd2 },  // R2 page-straddle offset 2
        '{32'hFE712E23, 6'd15, 1'b0, 1'b0, 64'h2000,   64'h2000,   1'b1, 32'h00702023, 4'd1 },  // R1 store imm cleared
        '{32'hFE712E23, 6'd6,  1'b0, 1'b0, 64'h2003,   64'h2000,   1'b1, 32'h00702023, 4'd3 },  // R3 misaligned store
        '{32'h000054A8, 6'd5,  1'b0, 1'b0, 64'h1001,   64'h1000,   1'b0, 32'h0000A501, 4'd4 },  // R4 C.LW
        '{32'h0000E00C, 6'd7,  1'b0, 1'b0, 64'h40,     64'h40,     1'b1, 32'h00B03021, 4'd6 },  // R6 C.SD on RV64
        '{32'h0000E00C, 6'd7,  1'b0, 1'b0, 64'h40,     64'h40,     1'b0, 32'h00B02025, 4'd6 },  // R6 C.FSW on RV32
        '{32'h00006402, 6'd13, 1'b0, 1'b0, 64'h104,    64'h100,    1'b1, 32'h00023401, 4'd4 },  // R4 C.LDSP
        '{32'h0000A026, 6'd23, 1'b1, 1'b0, 64'h80,     64'h80,     1'b1, 32'h00903025, 4'd5 },  // R5 C.FSDSP
        '{32'h0021A0AF, 6'd15, 1'b0, 1'b0, 64'h205,    64'h200,    1'b1, 32'h0021A0AF, 4'd7 },  // R7 atomic
        '{32'h68024373, 6'd21, 1'b1, 1'b0, 64'h300,    64'h300,    1'b1, 32'h68024373, 4'd7 },  // R7 hypervisor load
        '{32'h02056287, 6'd13, 1'b0, 1'b0, 64'h0,      64'h0,      1'b1, 32'h00000000, 4'd8 },  // R8 vector load
        '{32'h00853283, 6'd21, 1'b1, 1'b1, 64'h10,     64'h0,      1'b0, 32'h00002000, 4'd9 },  // R9 walk RV32
        '{32'h00853283, 6'd23, 1'b1, 1'b1, 64'h10,     64'h0,      1'b1, 32'h00003000, 4'd9 },  // R9 walk RV64
        '{32'h00853283, 6'd20, 1'b1, 1'b0, 64'h0,      64'h0,      1'b1, 32'h00003000, 4'd10},  // R10 two-stage RV64
        '{32'h00853283, 6'd20, 1'b0, 1'b0, 64'h0,      64'h0,      1'b1, 32'h00000000, 4'd10},  // R10 single stage
        '{32'h00853283, 6'd20, 1'b1, 1'b0, 64'h0,      64'h0,      1'b0, 32'h00002000, 4'd10},  // R10 two-stage RV32
        '{32'h00853283, 6'd12, 1'b0, 1'b0, 64'h3,      64'h0,      1'b1, 32'h00000000, 4'd11},  // R11 fetch page fault
        '{32'h00853283, 6'd2,  1'b0, 1'b0, 64'h3,      64'h0,      1'b1, 32'h00000000, 4'd11},  // R11 non-memory cause
        '{32'h01013087, 6'd5,  1'b0, 1'b0, 64'h507,    64'h500,    1'b1, 32'h0003B087, 4'd1 },  // R1 FLD imm cleared
        '{32'h00853283, 6'd13, 1'b0, 1'b0, 64'h623,    64'h600,    1'b1, 32'h0001B283, 4'd2 },  // R2 offset truncated
        '{32'h00853283, 6'd4,  1'b0, 1'b0, 64'h706,    64'h700,    1'b1, 32'h00003283, 4'd3 },  // R3 misaligned load
        '{32'h00000505, 6'd13, 1'b0, 1'b0, 64'h0,      64'h0,      1'b1, 32'h00000000, 4'd8 },  // R8 compressed non-memory
        '{32'h00002000, 6'd13, 1'b0, 1'b0, 64'h0,      64'h0,      1'b1, 32'h00003405, 4'd4 },  // R4 C.FLD
        '{32'h00853283, 6'd21, 1'b1, 1'b0, 64'h0,      64'h0,      1'b1, 32'h00003283, 4'd5 }   // R5 32-bit keeps 11
    };

    task automatic check(input logic [31:0] exp, input int req, input string what);
        checks++;
        if (tinst_o !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%08h expected=%08h", req, what, tinst_o, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        insn_i       = v.insn;
        cause_i      = v.cause;
        two_stage_i  = v.two;
        walk_i       = v.walk;
        fault_addr_i = v.fault;
        orig_addr_i  = v.orig;
        xlen64_i     = v.x64;
        commit_i     = 1'b1;
        @(negedge clk);
        commit_i     = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(32'h0, 12, "R12 reset value");
        rst_n = 1'b1;
        @(negedge clk);
        check(32'h0, 12, "R12 after reset release");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R12: no commit, changed inputs, output must hold
        apply(VECS[0]);
        insn_i  = 32'h0021A0AF;
        cause_i = 6'd15;
        repeat (3) @(negedge clk);
        check(32'h00013283, 12, "R12 hold without commit");

        // R12: reset mid-run clears output
        rst_n = 1'b0;
        @(negedge clk);
        check(32'h0, 12, "R12 reset mid-run");
        rst_n = 1'b1;
        @(negedge clk);

        // R3 vs R2: same straddle addresses, misaligned cause suppresses offset
        apply('{32'h00853283, 6'd4, 1'b0, 1'b0, 64'ha01000, 64'ha00ffe, 1'b1, 32'h00003283, 4'd3});
        check(32'h00003283, 3, "R3 straddle under misaligned cause");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule